// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block is the one-cycle register-transfer step that a sequencing controller drives: a small bank of general registers sits on a single shared bus. In every cycle a source code picks exactly one value for the bus. That value is either one of two external input words or the current contents of one of the registers. A per-register load vector then decides which registers take the bus value at the next rising clock edge.

Because each register has its own load bit, one source can be copied into any subset of the registers in a single cycle. The source choice and the load bits are sampled in the same cycle. The bus itself is a plain multiplexer output, so only one source can ever drive it.

Top module: `bus_xfer_unit`

## Requirements
- R1: A synchronous active-high reset (`rst`) clears every register to zero at the next rising edge, whatever the select and load inputs are.
- R2: Select code 0 puts `ext_a` on the bus and code 1 puts `ext_b` on the bus. Code 2+k puts register k on the bus (k = 0..NREG-1). `bus_o` always equals the selected source.
- R3: A select code of 2+NREG or higher puts zero on the bus.
- R4: Register k takes the bus value at the rising edge that ends a cycle in which `load_en[k]` is 1. Bit k of `load_en` belongs to register k.
- R5: A register whose load bit is 0 keeps its value across the edge.
- R6: If several load bits are 1 together, every register they name takes the same bus value.
- R7: A register that is both the source and a destination reloads its own current value, so it is unchanged.
- R8: If the select code is out of range and a load bit is 1, the named register is loaded with zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | SELW (default 3) | Bus source code |
| load_en | input | NREG (default 4) | Per-register load enables; bit k loads register k |
| ext_a | input | W (default 8) | External input word, select code 0 |
| ext_b | input | W (default 8) | External input word, select code 1 |
| bus_o | output | W | Current bus value |
| regs_o | output | NREG*W | Register contents; register k is in bits [k*W +: W] |

## Verification
The bench builds the block with its default parameters: four registers of 8 bits and a 3-bit select. With those values every select code can be driven, including the two codes past the last register, 6 and 7, which must put zero on the bus. Each load vector from 0000 to 1111 can also be driven. A table of transfers covers several corner cases:
- copies into one register, into several registers and into all four,
- a register used as both source and destination,
- a value passed from register to register,
- loads from an out-of-range code.

Directed steps then check that reset overrides an active load.

// File: rtl/bus_xfer_unit.sv
module bus_xfer_unit #(
  parameter int W    = 8,
  parameter int NREG = 4,
  parameter int SELW = $clog2(NREG + 2) + ((NREG + 2) == (1 << $clog2(NREG + 2)) ? 1 : 0)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SELW-1:0]   src_sel,
  input  logic [NREG-1:0]   load_en,
  input  logic [W-1:0]      ext_a,
  input  logic [W-1:0]      ext_b,
  output logic [W-1:0]      bus_o,
  output logic [NREG*W-1:0] regs_o
);

  localparam int NSRC = NREG + 2;

  logic [W-1:0] rf [NREG];
  logic [W-1:0] src [NSRC];

  assign src[0] = ext_a;
  assign src[1] = ext_b;

  genvar k;
  generate
    for (k = 0; k < NREG; k++) begin : g_reg
      assign src[k+2] = rf[k];
      assign regs_o[k*W +: W] = rf[k];

      always_ff @(posedge clk) begin
        if (rst)             rf[k] <= '0;
        else if (load_en[k]) rf[k] <= bus_o;
      end

      // R4
      load_takes_bus_chk: assert property (@(posedge clk) disable iff (rst)
        load_en[k] |=> rf[k] == $past(bus_o));
      // R5
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en[k] |=> $stable(rf[k]));
    end
  endgenerate

  always_comb begin
    bus_o = '0;
    for (int s = 0; s < NSRC; s++)
      if (int'(src_sel) == s) bus_o = src[s];
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> regs_o == '0);
  // R3
  bad_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
    int'(src_sel) >= NSRC |-> bus_o == '0);
  // R2
  ext_a_route_chk: assert property (@(posedge clk) disable iff (rst)
    src_sel == '0 |-> bus_o == ext_a);

endmodule

// File: tb/bus_xfer_unit_tb_top.sv
module bus_xfer_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8, NREG = 4, SELW = 3;

  logic clk = 0, rst = 1;
  logic [SELW-1:0] src_sel = '0;
  logic [NREG-1:0] load_en = '0;
  logic [W-1:0] ext_a = '0, ext_b = '0;
  logic [W-1:0] bus_o;
  logic [NREG*W-1:0] regs_o;

  int checks = 0, errors = 0;

  bus_xfer_unit #(.W(W), .NREG(NREG), .SELW(SELW)) dut_i (
    .clk(clk), .rst(rst), .src_sel(src_sel), .load_en(load_en),
    .ext_a(ext_a), .ext_b(ext_b), .bus_o(bus_o), .regs_o(regs_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // sel, load, ext_a, ext_b
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 4'b0001, 8'h11, 8'h22},
    {3'd1, 4'b0010, 8'h33, 8'h44},
    {3'd0, 4'b1100, 8'h5A, 8'h00},
    {3'd2, 4'b0010, 8'h00, 8'h00},
    {3'd1, 4'b1111, 8'hA5, 8'hC3},
    {3'd0, 4'b0000, 8'hFF, 8'hEE},
    {3'd0, 4'b0001, 8'h01, 8'h00},
    {3'd2, 4'b0001, 8'h77, 8'h66},
    {3'd2, 4'b1010, 8'h00, 8'h00},
    {3'd1, 4'b0100, 8'h00, 8'h9C},
    {3'd4, 4'b1001, 8'h00, 8'h00},
    {3'd6, 4'b0010, 8'h12, 8'h34},
    {3'd7, 4'b1000, 8'h56, 8'h78},
    {3'd5, 4'b0101, 8'h00, 8'h00}
  };

  logic [W-1:0] model [NREG];

  function automatic logic [W-1:0] exp_bus(input logic [SELW-1:0] s, input logic [W-1:0] a, input logic [W-1:0] b);
    if (s == 0) return a;
    if (s == 1) return b;
    if (int'(s) < NREG + 2) return model[int'(s) - 2];
    return '0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < NREG; k++)
      check(req, regs_o[k*W +: W], model[k]);
  endtask

  task automatic step(input logic [SELW-1:0] s, input logic [NREG-1:0] l, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [W-1:0] bv;
    src_sel = s; load_en = l; ext_a = a; ext_b = b;
    #1;
    bv = exp_bus(s, a, b);
    check(int'(s) >= NREG + 2 ? "R3 bus" : "R2 bus", bus_o, bv);
    @(posedge clk); #1;
    for (int k = 0; k < NREG; k++) if (l[k]) model[k] = bv;
    check_regs(req);
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = '0;
    load_en = '1; ext_a = 8'hAB;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check_regs("R1 reset clear");
    rst = 0;
    #(CLK_PERIOD/2);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      step(v[22:20], v[19:16], v[15:8], v[7:0], "R4 R5 R6 R7 R8 table");
    end

    // R7: register 2 reloads itself
    step(3'd4, 4'b0100, 8'h00, 8'h00, "R7 self load");
    // R6: broadcast into every register
    step(3'd0, 4'b1111, 8'h3C, 8'h00, "R6 broadcast");
    // R8: an out-of-range code with every load bit set
    step(3'd7, 4'b1111, 8'hFF, 8'hFF, "R8 bad code load");
    // R5: no load bit set, so nothing changes
    step(3'd1, 4'b0000, 8'h00, 8'h99, "R5 hold");
    step(3'd1, 4'b0011, 8'h00, 8'h99, "R4 load");

    // R1: reset overrides an active load
    rst = 1; src_sel = 3'd0; ext_a = 8'hEE; load_en = '1;
    @(posedge clk); #1;
    for (int k = 0; k < NREG; k++) model[k] = '0;
    check_regs("R1 reset over load");
    rst = 0; load_en = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule